// File: doc/BRIEF.md
# Handshaked Synchronous Serial Transceiver

This block moves one byte at a time over a clocked serial link and paces each byte with a ready handshake between the two ends. The local side loads a transmit byte through a single-cycle write strobe. The block then raises its ready output to tell the peer that a byte is waiting. Bits leave least significant first on the serial data output. At the same time the peer's bits are shifted in, and the assembled byte appears on the received-data port once the eighth bit has been sampled.

There are two clocking modes. In internal-clock mode the block is the master. It generates the shift clock from the system clock through a 3-bit divider select, and it waits until the peer's ready input has been held active long enough before it sends any clock. In external-clock mode the peer supplies the shift clock. A byte is armed as soon as a transmit byte has been written while the peer's ready is active, and the busy output tells the peer that the byte is in progress.

A single polarity select inverts the ready output, the ready input and the busy output together. An enable input holds the whole block in its initial state while it is low.

Top module: `hs_serial_xcvr`

## Requirements
- R1: While `init_en` is 0, `rdy_o` is at its inactive level, `xfer_active` is 0, and writes and the ready input have no effect. Setting `init_en` back to 1 does not by itself start a transfer.
- R2: A write (`tx_wr`=1 for one cycle while `init_en`=1 and no transfer is running) makes `rdy_o` active on the next cycle. A write made during a transfer is ignored, so no further transfer follows.
- R3: `rdy_o` returns to inactive when the shift clock first goes low. In internal mode this is the cycle the transfer starts. In external mode it is the first falling edge of `sclk_i`.
- R4: In internal mode, with a byte written, the transfer starts on the clock edge that follows 3·2^`div_sel` consecutive system cycles of active ready input. A shorter active pulse starts nothing.
- R5: Once a byte has started, making the ready input inactive does not stop it, and all 8 bits are exchanged.
- R6: `sclk_o` idles high and goes low in the start cycle. In internal mode its period is 2^(`div_sel`+1) system cycles, and it produces exactly 8 rising edges per byte. In external mode it stays high.
- R7: `sdo` presents transmit bit 0 first and changes only on falling shift-clock edges. `sdi` is sampled on rising edges, and the first sampled bit becomes `rx_data[0]`.
- R8: `xfer_active` is 1 from the start cycle up to the eighth rising shift-clock edge. It drops on that edge, and `rx_data` is updated on the same edge.
- R9: In external mode a transfer starts on the edge after a written byte and an active ready input are both present. Bits shift on `sclk_i` edges that have been brought into the system-clock domain.
- R10: When `hs_invert`=1, active means low on `rdy_o`, `rdy_i` and `busy_o`; otherwise active means high. `busy_o` is active exactly while `xfer_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| init_en | input | 1 | 0 holds the block in its initial state |
| ext_clk_mode | input | 1 | 1 selects the peer-supplied shift clock |
| hs_invert | input | 1 | Inverts the handshake pins |
| div_sel | input | 3 | Internal shift-clock divider select |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_data | input | 8 | Transmit byte |
| sclk_o | output | 1 | Shift clock driven in internal mode |
| sclk_i | input | 1 | Shift clock from the peer in external mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| rdy_o | output | 1 | Ready indication to the peer |
| rdy_i | input | 1 | Ready indication from the peer |
| busy_o | output | 1 | Transfer-in-progress indication to the peer |
| xfer_active | output | 1 | Status: byte transfer running |
| rx_data | output | 8 | Last received byte |

## Verification
The assertions take four things for granted about the inputs. `rdy_i` and `sdi` are synchronous to `clk`. `ext_clk_mode`, `hs_invert` and `div_sel` stay constant while a byte is running. In external mode each `sclk_i` phase lasts several system cycles, so the synchronizer can see every edge. The stimulus changes configuration only between bytes with the ready input inactive. It drives every input on the falling system-clock edge and holds each phase of the external shift clock for eight system cycles. Random bytes, polarities, divider values and modes come from a fixed seed. Directed cases cover the widest divider, a ready pulse one cycle too short, ready dropped mid-byte, and a write issued during a transfer.

// File: rtl/hs_xcvr_pkg.sv
// Package: shared sizing for the handshaked serial transceiver.
// Assumes one byte per handshake and a 3-bit divider select.
package hs_xcvr_pkg;
    parameter int DATA_W = 8;
    parameter int DIV_W  = 3;
    // Largest divider select value and the widths that follow from it.
    localparam int MAX_SEL = (1 << DIV_W) - 1;
    localparam int HALF_W  = MAX_SEL + 1;                       // holds 2^MAX_SEL - 1
    localparam int QUAL_W  = $clog2(3 * (1 << MAX_SEL) + 1);   // holds 3*2^MAX_SEL
    localparam int BIT_W   = $clog2(DATA_W);
endpackage

// File: rtl/hs_rdy_qual.sv
// Ready qualifier: reports that the peer's ready has been active for at
// least 1.5 shift-clock periods (3 half periods of 2^div_sel cycles).
// Assumes rdy_act is already synchronous to clk and polarity-corrected.
module hs_rdy_qual
    import hs_xcvr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             rdy_act,
    input  logic [DIV_W-1:0] div_sel,
    output logic             qualified
);
    logic [QUAL_W-1:0] cnt_q;
    logic [QUAL_W-1:0] thresh;

    assign thresh    = QUAL_W'(3) << div_sel;
    assign qualified = (cnt_q >= thresh);

    // Count consecutive active cycles, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !rdy_act)
            cnt_q <= '0;
        else if (cnt_q < thresh)
            cnt_q <= cnt_q + QUAL_W'(1);
    end
endmodule

// File: rtl/hs_half_timer.sv
// Half-period timer: pulses once every 2^div_sel system cycles while run
// is high; restarts from zero whenever run is low.
// Assumes div_sel is stable while run is high.
module hs_half_timer
    import hs_xcvr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             half_tick
);
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] last;

    assign last      = (HALF_W'(1) << div_sel) - HALF_W'(1);
    assign half_tick = run && (cnt_q == last);

    // Free-running count inside one half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || half_tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + HALF_W'(1);
    end
endmodule

// File: rtl/hs_edge_sync.sv
// External shift-clock synchronizer: brings sclk_i into the clk domain and
// reports rising and falling edges as single-cycle pulses.
// Assumes each sclk_i phase lasts at least 3 system cycles.
module hs_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sync_q;

    assign rise = sync_q[STAGES-1] & ~sync_q[STAGES];
    assign fall = ~sync_q[STAGES-1] & sync_q[STAGES];

    // Shift the line level through the synchronizer chain; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '1;
        else
            sync_q <= {sync_q[STAGES-1:0], sclk_i};
    end
endmodule

// File: rtl/hs_shifter.sv
// Shift engine: exchanges one DATA_W-bit unit LSB first. In internal mode
// it builds the shift clock from half_tick; in external mode it follows the
// synchronized peer clock edges. Output data moves on falling edges and
// input data is captured on rising edges.
// Assumes start is never asserted while a unit is running.
module hs_shifter
    import hs_xcvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_en,
    input  logic              ext_mode,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              start,
    input  logic              half_tick,
    input  logic              ext_rise,
    input  logic              ext_fall,
    input  logic              sdi,
    output logic              active,
    output logic              sclk,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_data
);
    logic [DATA_W-1:0] sh_q;
    logic [BIT_W-1:0]  bit_q;
    logic              rise_ev;
    logic              fall_ev;
    logic              last_rise;

    assign rise_ev   = ext_mode ? ext_rise : (half_tick && !sclk);
    assign fall_ev   = ext_mode ? ext_fall : (half_tick && sclk);
    assign last_rise = active && rise_ev && (bit_q == BIT_W'(DATA_W - 1));

    // Transfer sequencing: load, start, shift on edges, finish after last bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !init_en) begin
            active <= 1'b0;
            sclk   <= 1'b1;
            sdo    <= 1'b0;
            sh_q   <= '0;
            bit_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            sclk   <= ext_mode;
            sdo    <= sh_q[0];
            bit_q  <= '0;
        end else if (active) begin
            if (rise_ev) begin
                sclk <= 1'b1;
                sh_q <= {sdi, sh_q[DATA_W-1:1]};
                if (last_rise)
                    active <= 1'b0;
                else
                    bit_q <= bit_q + BIT_W'(1);
            end else if (fall_ev) begin
                sclk <= ext_mode;
                sdo  <= sh_q[0];
            end
        end else if (load) begin
            sh_q <= load_data;
        end
    end

    // Received byte register, updated on the final rising edge only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_data <= '0;
        else if (init_en && last_rise)
            rx_data <= {sdi, sh_q[DATA_W-1:1]};
    end

    AST_RUN_TO_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && !$past(last_rise) && $past(init_en) && init_en) |-> active); // R5
    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> sclk); // R6
    AST_EXT_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ext_mode) && ext_mode) |-> sclk); // R6
endmodule

// File: rtl/hs_serial_xcvr.sv
// Top: handshaked synchronous serial transceiver. Holds the pending-byte
// and ready-output state, picks the start condition for the selected
// clocking mode and applies the handshake polarity.
// Assumes rdy_i and sdi are synchronous to clk and that the mode, polarity
// and divider inputs change only while no transfer runs.
module hs_serial_xcvr
    import hs_xcvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_en,
    input  logic              ext_clk_mode,
    input  logic              hs_invert,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              sclk_o,
    input  logic              sclk_i,
    output logic              sdo,
    input  logic              sdi,
    output logic              rdy_o,
    input  logic              rdy_i,
    output logic              busy_o,
    output logic              xfer_active,
    output logic [DATA_W-1:0] rx_data
);
    logic rdy_in_act;
    logic rdy_qual;
    logic pending_q;
    logic rdy_act_q;
    logic active;
    logic wr_ok;
    logic start;
    logic half_tick;
    logic ext_rise;
    logic ext_fall;

    assign rdy_in_act = rdy_i ^ hs_invert;
    assign wr_ok      = tx_wr && init_en && !active;
    assign start      = pending_q && !active && !tx_wr &&
                        (ext_clk_mode ? rdy_in_act : rdy_qual);

    hs_rdy_qual u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!init_en),
        .rdy_act   (rdy_in_act),
        .div_sel   (div_sel),
        .qualified (rdy_qual)
    );

    hs_half_timer u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (active && !ext_clk_mode),
        .div_sel   (div_sel),
        .half_tick (half_tick)
    );

    hs_edge_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk_i),
        .rise   (ext_rise),
        .fall   (ext_fall)
    );

    hs_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_en   (init_en),
        .ext_mode  (ext_clk_mode),
        .load      (wr_ok),
        .load_data (tx_data),
        .start     (start),
        .half_tick (half_tick),
        .ext_rise  (ext_rise),
        .ext_fall  (ext_fall),
        .sdi       (sdi),
        .active    (active),
        .sclk      (sclk_o),
        .sdo       (sdo),
        .rx_data   (rx_data)
    );

    // Pending byte and ready-output state across write, start and first low clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !init_en) begin
            pending_q <= 1'b0;
            rdy_act_q <= 1'b0;
        end else if (wr_ok) begin
            pending_q <= 1'b1;
            rdy_act_q <= 1'b1;
        end else begin
            if (start)
                pending_q <= 1'b0;
            if (start && !ext_clk_mode)
                rdy_act_q <= 1'b0;
            else if (active && ext_clk_mode && ext_fall)
                rdy_act_q <= 1'b0;
        end
    end

    assign rdy_o       = rdy_act_q ^ hs_invert;
    assign busy_o      = active ^ hs_invert;
    assign xfer_active = active;

    AST_RDY_IDLE_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        !init_en |=> !rdy_act_q); // R1
    AST_WRITE_RAISES_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && init_en && !xfer_active) |=> rdy_act_q); // R2
    AST_RDY_DROPS_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(active) && !$past(ext_clk_mode)) |-> !rdy_act_q); // R3
    AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(active) && !$past(ext_clk_mode)) |-> $past(rdy_qual)); // R4
    AST_EXT_START_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(active) && $past(ext_clk_mode)) |-> $past(rdy_in_act)); // R9
endmodule

// File: tb/tb_hs_serial_xcvr.sv
`timescale 1ns/1ps
module tb_hs_serial_xcvr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_en = 1'b0;
    logic       ext_clk_mode = 1'b0;
    logic       hs_invert = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       sclk_i = 1'b1;
    logic       sdi = 1'b0;
    logic       rdy_i = 1'b0;
    logic       sclk_o, sdo, rdy_o, busy_o, xfer_active;
    logic [7:0] rx_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    hs_serial_xcvr dut (
        .clk(clk), .rst_n(rst_n), .init_en(init_en), .ext_clk_mode(ext_clk_mode),
        .hs_invert(hs_invert), .div_sel(div_sel), .tx_wr(tx_wr), .tx_data(tx_data),
        .sclk_o(sclk_o), .sclk_i(sclk_i), .sdo(sdo), .sdi(sdi), .rdy_o(rdy_o),
        .rdy_i(rdy_i), .busy_o(busy_o), .xfer_active(xfer_active), .rx_data(rx_data)
    );

    function automatic int f_thresh(input int d);
        return 3 << d;
    endfunction

    function automatic int f_period(input int d);
        return 2 << d;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        tx_wr = 1'b1; tx_data = b;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic run_int(input int d, input bit inv, input logic [7:0] txb,
                           input logic [7:0] peer, input bit drop_mid, input bit wr_mid);
        int w, rises, last, tmo;
        bit seen, done, prev;
        logic [7:0] mon;
        @(negedge clk);
        ext_clk_mode = 1'b0; div_sel = 3'(d); hs_invert = inv; rdy_i = inv;
        repeat (2) @(negedge clk);
        write_byte(txb);
        check(rdy_o == !inv, "R2 rdy_o after write", rdy_o, !inv);
        sdi = peer[0]; rdy_i = !inv;
        w = 0; rises = 0; last = 0; seen = 0; done = 0; prev = 1; mon = 0;
        tmo = f_thresh(d) + 10 * f_period(d) + 50;
        while (!done && w < tmo) begin
            @(negedge clk);
            w++;
            tx_wr = 1'b0;
            if (!seen && xfer_active) begin
                seen = 1;
                check(w == f_thresh(d) + 1, "R4 start cycle", w, f_thresh(d) + 1);
                check(sclk_o == 1'b0, "R6 sclk low at start", sclk_o, 0);
                check(rdy_o == inv, "R3 rdy_o inactive at first low", rdy_o, inv);
                check(busy_o == !inv, "R10 busy_o active level", busy_o, !inv);
            end
            if (sclk_o && !prev) begin
                if (rises < 8) mon[rises] = sdo;
                if (rises > 0) check(w - last == f_period(d), "R6 sclk period", w - last, f_period(d));
                last = w;
                rises++;
                if (rises < 8) sdi = peer[rises];
                if (drop_mid && rises == 1) rdy_i = inv;
                if (wr_mid && rises == 3) begin tx_wr = 1'b1; tx_data = ~txb; end
            end
            if (seen && !xfer_active) done = 1;
            prev = sclk_o;
        end
        check(done, "R5 transfer completed", done, 1);
        check(w == last, "R8 status drops on 8th rise", w, last);
        check(rises == 8, "R6 rising edge count", rises, 8);
        check(mon == txb, "R7 sdo bits LSB first", mon, txb);
        check(rx_data == peer, "R7 rx_data", rx_data, peer);
        check(sclk_o == 1'b1, "R6 sclk idle high", sclk_o, 1);
        seen = 0;
        repeat (12) begin @(negedge clk); if (xfer_active) seen = 1; end
        check(!seen, "R2 no transfer after mid-transfer write", seen, 0);
        check(rdy_o == inv, "R3 rdy_o stays inactive", rdy_o, inv);
        rdy_i = inv;
    endtask

    task automatic run_short(input int d, input bit inv);
        bit any;
        @(negedge clk);
        ext_clk_mode = 1'b0; div_sel = 3'(d); hs_invert = inv; rdy_i = inv;
        repeat (2) @(negedge clk);
        write_byte(8'h5A);
        any = 0;
        rdy_i = !inv;
        repeat (f_thresh(d) - 1) begin @(negedge clk); if (xfer_active) any = 1; end
        rdy_i = inv;
        repeat (20) begin @(negedge clk); if (xfer_active || !sclk_o) any = 1; end
        check(!any, "R4 short ready pulse starts nothing", any, 0);
    endtask

    task automatic run_ext(input bit inv, input logic [7:0] txb, input logic [7:0] peer);
        logic [7:0] mon;
        bit any;
        @(negedge clk);
        ext_clk_mode = 1'b1; hs_invert = inv; rdy_i = inv; sclk_i = 1'b1;
        repeat (2) @(negedge clk);
        write_byte(txb);
        check(rdy_o == !inv, "R2 rdy_o after write (ext)", rdy_o, !inv);
        any = 0;
        repeat (5) begin @(negedge clk); if (xfer_active) any = 1; end
        check(!any, "R9 no start without ready", any, 0);
        rdy_i = !inv;
        @(negedge clk);
        check(busy_o == !inv, "R9 busy active after ready", busy_o, !inv);
        check(xfer_active == 1'b1, "R8 status set at start", xfer_active, 1);
        check(rdy_o == !inv, "R3 rdy_o active until first fall", rdy_o, !inv);
        mon = 0;
        for (int b = 0; b < 8; b++) begin
            sclk_i = 1'b0; sdi = peer[b];
            repeat (8) @(negedge clk);
            if (b == 0) check(rdy_o == inv, "R3 rdy_o inactive after first fall", rdy_o, inv);
            if (b == 0) check(sclk_o == 1'b1, "R6 sclk_o high in ext mode", sclk_o, 1);
            mon[b] = sdo;
            sclk_i = 1'b1;
            repeat (8) @(negedge clk);
        end
        check(mon == txb, "R9 sdo bits (ext)", mon, txb);
        check(rx_data == peer, "R9 rx_data (ext)", rx_data, peer);
        check(busy_o == inv, "R9 busy inactive after byte", busy_o, inv);
        check(xfer_active == 1'b0, "R8 status clear after byte", xfer_active, 0);
        rdy_i = inv;
    endtask

    task automatic run_init_hold();
        bit any;
        @(negedge clk);
        ext_clk_mode = 1'b0; hs_invert = 1'b0; div_sel = 3'd0; rdy_i = 1'b0;
        init_en = 1'b0;
        write_byte(8'hC3);
        check(rdy_o == 1'b0, "R1 rdy_o inactive in init", rdy_o, 0);
        any = 0;
        rdy_i = 1'b1;
        repeat (30) begin @(negedge clk); if (xfer_active || rdy_o) any = 1; end
        check(!any, "R1 nothing happens in init", any, 0);
        init_en = 1'b1;
        repeat (20) begin @(negedge clk); if (xfer_active || rdy_o) any = 1; end
        check(!any, "R1 no start after leaving init", any, 0);
        rdy_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rdy_o == 1'b0, "R1 reset rdy_o", rdy_o, 0);
        check(busy_o == 1'b0, "R10 reset busy_o", busy_o, 0);
        check(sclk_o == 1'b1, "R6 reset sclk_o", sclk_o, 1);
        check(xfer_active == 1'b0, "R8 reset status", xfer_active, 0);
        check(rx_data == 8'h00, "R7 reset rx_data", rx_data, 0);
        init_en = 1'b1;

        run_int(0, 1'b0, 8'hA5, 8'h3C, 1'b0, 1'b0);
        run_int(7, 1'b0, 8'h81, 8'h7E, 1'b0, 1'b0);
        run_int(2, 1'b1, 8'h0F, 8'hF0, 1'b1, 1'b0);   // R5 ready dropped mid-byte
        run_int(1, 1'b0, 8'h96, 8'h69, 1'b0, 1'b1);   // R2 write during transfer
        run_short(2, 1'b0);
        run_short(0, 1'b1);
        run_init_hold();
        run_ext(1'b0, 8'hD2, 8'h4B);
        run_ext(1'b1, 8'h01, 8'h80);

        for (int i = 0; i < 10; i++) begin
            logic [7:0] a, p;
            a = 8'($urandom);
            p = 8'($urandom);
            if ($urandom_range(0, 2) == 0)
                run_ext(1'($urandom), a, p);
            else
                run_int(int'($urandom_range(0, 3)), 1'($urandom), a, p,
                        1'($urandom), 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule